// File: doc/BRIEF.md
# Processor Sleep and Wake Controller

This block sequences the clock and power gates of a small processor core as it goes into and comes out of low-power states. Three single-cycle request strobes can put the core to sleep: a wait-for-interrupt strobe, a wait-for-event strobe and an exception-return-to-thread strobe. The exception-return strobe only counts when the sleep-on-exit configuration bit is set. A depth configuration bit chooses what a request leads to. Light sleep gates only the processor clock. Deep sleep also stops the system clock and removes PLL and memory power.

A one-bit event latch decides whether a wait-for-event request sleeps. Activity seen while the core runs sets the latch. A wait-for-event request that finds the latch set clears it and the core keeps running. Light sleep ends on a pending prioritized interrupt. When the sleep was entered by wait-for-event alone, an external event pulse also ends it. Deep sleep ignores both and ends only on a wake-up interrupt controller request. That request starts a staged restart: power returns first, the system clock follows after a programmable settling time, and the processor clock comes last.

Top module: `sleep_wake_ctl`

## Requirements
- R1: After reset `state_o` is 0 (run), all four enables are 1 and the event latch is clear, so a wait-for-event request made straight after reset enters sleep.
- R2: In run, with `sleep_deep`=0 and `irq_pend` low, `wfi_req` gives `state_o`=1 (light sleep) one cycle later: `cpu_clk_en`=0 while `sys_clk_en`, `pll_pwr_en` and `mem_pwr_en` stay 1.
- R3: With `sleep_deep`=1, any accepted sleep request gives `state_o`=2 (deep sleep) one cycle later, with all four enables at 0.
- R4: In run, `ext_evt` or `irq_pend` sets the event latch. A `wfe_req` that finds the latch set clears it and the core stays in run. A `wfe_req` that finds the latch clear enters sleep.
- R5: `exc_ret_thread` enters the selected sleep state when `sleep_on_exit`=1. When `sleep_on_exit`=0 it is ignored.
- R6: Light sleep entered through `wfi_req` or through sleep-on-exit returns to run one cycle after `irq_pend`. It ignores `ext_evt`.
- R7: Light sleep entered through `wfe_req` alone returns to run one cycle after either `irq_pend` or `ext_evt`.
- R8: Deep sleep ignores `irq_pend` and `ext_evt`. It is left only through `wic_wake`.
- R9: One cycle after `wic_wake` in deep sleep, `state_o` becomes 3 (power ramp) with PLL and memory power at 1 and both clocks at 0. It stays there for WAKE_DELAY cycles. Then `state_o` is 4 (restart) for one cycle, with the system clock at 1 and the processor clock at 0. After that the core is in run.
- R10: While `irq_pend` is high in run, no entry path puts the core to sleep.
- R11: `wic_wake` has no effect in light sleep.
- R12: When `wfi_req` and `wfe_req` arrive in the same cycle, the sleep behaves as wait-for-interrupt, so `ext_evt` does not end it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wfi_req | input | 1 | Wait-for-interrupt strobe |
| wfe_req | input | 1 | Wait-for-event strobe |
| exc_ret_thread | input | 1 | Exception return to thread mode strobe |
| irq_pend | input | 1 | Enabled prioritized interrupt pending |
| ext_evt | input | 1 | External event pulse |
| wic_wake | input | 1 | Wake-up interrupt controller request |
| sleep_deep | input | 1 | 1 selects deep sleep, 0 selects light sleep |
| sleep_on_exit | input | 1 | Enables sleep on exception return |
| cpu_clk_en | output | 1 | Processor clock enable |
| sys_clk_en | output | 1 | System clock enable |
| pll_pwr_en | output | 1 | PLL power enable |
| mem_pwr_en | output | 1 | Memory power enable |
| state_o | output | 3 | 0 run, 1 light, 2 deep, 3 power ramp, 4 restart |

## Verification
Every request and wake input takes effect on the first rising edge that samples it, so its result is due one cycle later. The only exception is the deep-sleep exit: after the ramp state begins, the restart state is due WAKE_DELAY cycles later and run one cycle after that. The bench drives each input on a falling edge, lets exactly one rising edge pass, and compares state and enables on the following falling edge. The ramp is walked one cycle per table row, so an early or late transition fails on its own row.

// File: rtl/sleep_wake_ctl.sv
module sleep_wake_ctl #(
  parameter int WAKE_DELAY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wfi_req,
  input  logic       wfe_req,
  input  logic       exc_ret_thread,
  input  logic       irq_pend,
  input  logic       ext_evt,
  input  logic       wic_wake,
  input  logic       sleep_deep,
  input  logic       sleep_on_exit,
  output logic       cpu_clk_en,
  output logic       sys_clk_en,
  output logic       pll_pwr_en,
  output logic       mem_pwr_en,
  output logic [2:0] state_o
);
  localparam int CW = (WAKE_DELAY > 1) ? $clog2(WAKE_DELAY) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(WAKE_DELAY - 1);

  typedef enum logic [2:0] {
    S_RUN   = 3'd0,
    S_LIGHT = 3'd1,
    S_DEEP  = 3'd2,
    S_RAMP  = 3'd3,
    S_RESTART = 3'd4
  } pstate_t;

  pstate_t       st;
  logic          evt_latch;
  logic          evt_wake_ok;
  logic [CW-1:0] ramp_cnt;

  wire running   = (st == S_RUN);
  wire exit_req  = exc_ret_thread & sleep_on_exit;
  wire wfe_sleep = wfe_req & ~evt_latch;
  wire go_sleep  = running & ~irq_pend & (wfi_req | wfe_sleep | exit_req);
  wire light_wake = irq_pend | (evt_wake_ok & ext_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_RUN;
      evt_wake_ok <= 1'b0;
      ramp_cnt    <= '0;
    end else begin
      case (st)
        S_RUN: if (go_sleep) begin
          st          <= sleep_deep ? S_DEEP : S_LIGHT;
          evt_wake_ok <= wfe_sleep & ~wfi_req & ~exit_req;
        end
        S_LIGHT: if (light_wake) st <= S_RUN;
        S_DEEP: if (wic_wake) begin
          st       <= S_RAMP;
          ramp_cnt <= '0;
        end
        S_RAMP: begin
          if (ramp_cnt == CNT_LAST) st <= S_RESTART;
          else ramp_cnt <= ramp_cnt + 1'b1;
        end
        S_RESTART: st <= S_RUN;
        default: st <= S_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_latch <= 1'b0;
    else if (running) begin
      if (wfe_req && evt_latch) evt_latch <= 1'b0;
      else if (ext_evt || irq_pend) evt_latch <= 1'b1;
    end
  end

  assign cpu_clk_en = (st == S_RUN);
  assign sys_clk_en = (st == S_RUN) | (st == S_LIGHT) | (st == S_RESTART);
  assign pll_pwr_en = (st != S_DEEP);
  assign mem_pwr_en = (st != S_DEEP);
  assign state_o    = st;
endmodule

module sleep_wake_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_pend,
  input logic       wic_wake,
  input logic       cpu_clk_en,
  input logic       sys_clk_en,
  input logic       pll_pwr_en,
  input logic       mem_pwr_en,
  input logic [2:0] state_o
);
  // R10
  irq_blocks_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && irq_pend) |=> cpu_clk_en);
  // R9
  sys_after_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_clk_en) |-> ($past(pll_pwr_en) && $past(mem_pwr_en)));
  // R9
  cpu_after_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> $past(sys_clk_en));
  // R8
  deep_exit_wic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_pwr_en) |-> $past(wic_wake));
  // R3
  deep_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_pwr_en) |-> (!sys_clk_en && !mem_pwr_en && !cpu_clk_en));
  // R6
  light_irq_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1 && irq_pend) |=> cpu_clk_en);
  // R2
  light_keeps_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1) |-> (sys_clk_en && pll_pwr_en && mem_pwr_en && !cpu_clk_en));
endmodule

bind sleep_wake_ctl sleep_wake_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .wic_wake(wic_wake),
  .cpu_clk_en(cpu_clk_en), .sys_clk_en(sys_clk_en), .pll_pwr_en(pll_pwr_en),
  .mem_pwr_en(mem_pwr_en), .state_o(state_o)
);

// File: tb/sleep_wake_ctl_test.sv
module sleep_wake_ctl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wfi_req = 0, wfe_req = 0, exc_ret_thread = 0, irq_pend = 0;
  logic ext_evt = 0, wic_wake = 0, sleep_deep = 0, sleep_on_exit = 0;
  logic cpu_clk_en, sys_clk_en, pll_pwr_en, mem_pwr_en;
  logic [2:0] state_o;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  sleep_wake_ctl #(.WAKE_DELAY(4)) uut (
    .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
    .exc_ret_thread(exc_ret_thread), .irq_pend(irq_pend), .ext_evt(ext_evt),
    .wic_wake(wic_wake), .sleep_deep(sleep_deep), .sleep_on_exit(sleep_on_exit),
    .cpu_clk_en(cpu_clk_en), .sys_clk_en(sys_clk_en), .pll_pwr_en(pll_pwr_en),
    .mem_pwr_en(mem_pwr_en), .state_o(state_o)
  );

  // row: req[18:15] | wfi wfe exr irq evt wic deep soe [14:7] | state [6:4] | cpu sys pll mem [3:0]
  localparam int NV = 31;
  localparam logic [18:0] VEC [NV] = '{
    {4'd2,  8'b1000_0000, 3'd1, 4'b0111}, // R2 wfi to light sleep
    {4'd6,  8'b0000_1000, 3'd1, 4'b0111}, // R6 event ignored
    {4'd11, 8'b0000_0100, 3'd1, 4'b0111}, // R11 wic ignored in light sleep
    {4'd6,  8'b0001_0000, 3'd0, 4'b1111}, // R6 irq wakes
    {4'd10, 8'b1001_0000, 3'd0, 4'b1111}, // R10 wfi blocked, latch set
    {4'd4,  8'b0100_0000, 3'd0, 4'b1111}, // R4 wfe consumes latch
    {4'd4,  8'b0100_0000, 3'd1, 4'b0111}, // R4 wfe with clear latch sleeps
    {4'd7,  8'b0000_1000, 3'd0, 4'b1111}, // R7 event wakes wfe sleep
    {4'd4,  8'b0000_1000, 3'd0, 4'b1111}, // R4 event sets latch
    {4'd4,  8'b0100_0000, 3'd0, 4'b1111}, // R4 consumed
    {4'd7,  8'b0100_0000, 3'd1, 4'b0111}, // R7 wfe sleep
    {4'd7,  8'b0001_0000, 3'd0, 4'b1111}, // R7 irq wakes wfe sleep
    {4'd5,  8'b0010_0000, 3'd0, 4'b1111}, // R5 exit ignored with bit clear
    {4'd5,  8'b0010_0001, 3'd1, 4'b0111}, // R5 sleep on exit
    {4'd6,  8'b0001_0000, 3'd0, 4'b1111}, // R6 irq wakes
    {4'd12, 8'b1100_0000, 3'd1, 4'b0111}, // R12 wfi and wfe together
    {4'd12, 8'b0000_1000, 3'd1, 4'b0111}, // R12 event ignored
    {4'd6,  8'b0001_0000, 3'd0, 4'b1111}, // R6 irq wakes
    {4'd3,  8'b1000_0010, 3'd2, 4'b0000}, // R3 deep sleep
    {4'd8,  8'b0001_0000, 3'd2, 4'b0000}, // R8 irq ignored
    {4'd8,  8'b0000_1000, 3'd2, 4'b0000}, // R8 event ignored
    {4'd9,  8'b0000_0100, 3'd3, 4'b0011}, // R9 ramp cycle 1
    {4'd9,  8'b0000_0000, 3'd3, 4'b0011}, // R9 ramp cycle 2
    {4'd9,  8'b0000_0000, 3'd3, 4'b0011}, // R9 ramp cycle 3
    {4'd9,  8'b0000_0000, 3'd3, 4'b0011}, // R9 ramp cycle 4
    {4'd9,  8'b0000_0000, 3'd4, 4'b0111}, // R9 restart
    {4'd9,  8'b0000_0000, 3'd0, 4'b1111}, // R9 run
    {4'd10, 8'b0101_0010, 3'd0, 4'b1111}, // R10 wfe blocked
    {4'd10, 8'b0011_0011, 3'd0, 4'b1111}, // R10 exit blocked
    {4'd3,  8'b0010_0011, 3'd2, 4'b0000}, // R3 deep via sleep on exit
    {4'd9,  8'b0000_0100, 3'd3, 4'b0011}  // R9 ramp from exit sleep
  };

  task automatic drive(input logic [7:0] v);
    {wfi_req, wfe_req, exc_ret_thread, irq_pend, ext_evt, wic_wake, sleep_deep, sleep_on_exit} = v;
  endtask

  task automatic check(input int req, input logic [2:0] st, input logic [3:0] en);
    logic [6:0] act;
    act = {state_o, cpu_clk_en, sys_clk_en, pll_pwr_en, mem_pwr_en};
    checks++;
    if (act !== {st, en}) begin
      errors++;
      $display("FAIL R%0d: state/en actual %0d/%b expected %0d/%b", req, act[6:4], act[3:0], st, en);
    end
  endtask

  task automatic step(input logic [7:0] v, input int req, input logic [2:0] st, input logic [3:0] en);
    drive(v);
    @(negedge clk);
    drive(8'h00);
    check(req, st, en);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(1, 3'd0, 4'b1111); // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 3'd0, 4'b1111); // R1 after release
    for (int i = 0; i < NV; i++)
      step(VEC[i][14:7], int'(VEC[i][18:15]), VEC[i][6:4], VEC[i][3:0]);
    // R1: reset from ramp returns to run and clears the event latch (set earlier by irq)
    rst_n = 1'b0;
    @(negedge clk);
    check(1, 3'd0, 4'b1111);
    rst_n = 1'b1;
    @(negedge clk);
    step(8'b0100_0000, 1, 3'd1, 4'b0111); // R1 wfe sleeps after reset
    step(8'b0000_0100, 11, 3'd1, 4'b0111); // R11 wic ignored
    step(8'b0000_1000, 7, 3'd0, 4'b1111); // R7 event wakes
    step(8'b0000_0000, 2, 3'd0, 4'b1111); // R2 idle stays in run
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule